// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is the serial test port of a memory device. A four-wire serial interface (test clock, mode select, serial data in, serial data out) plus an optional asynchronous active-low reset steers a sixteen-state controller. Through that controller a tester loads a 3-bit instruction, and the instruction decides which data register sits between the serial input and the serial output. The data register is one of three: a 32-bit identification register, a single-bit bypass register, or a boundary register of parameterised length.

The boundary register samples the device's pin values when a capture step occurs. A separate update stage holds the values that the register presents to the pins in test mode. When the external-test instruction is active, the block raises a mode output so that the surrounding logic drives the pins from that update stage instead of from normal operation. The serial output has an enable that the pad uses as its tristate control, so the pin is high-impedance whenever no shift is in progress.

Top module: `scan_tap`

## Requirements
- R1: Mode select and serial data in are sampled on the rising test-clock edge, and the serial output `tdo` changes only on the falling test-clock edge.
- R2: Five consecutive rising edges with mode select high bring the controller to the reset state from any state, and a low level on `trstN` puts it there asynchronously.
- R3: In the reset state the active instruction is the identify code 3'b001. A data scan made after reset shifts out the 32-bit `ID_CODE` least significant bit first.
- R4: The instruction capture step loads 3'b001 into the instruction shift stage. The stage shifts out least significant bit first, with new bits entering at the most significant bit, and the update step copies it to the active instruction.
- R5: Instruction 3'b000 (external test) places the boundary register on the serial path and holds `extestMode` high. The update step then copies the shifted boundary bits to `pinOut`.
- R6: Instruction 3'b010 (sample/preload) makes the data capture step load `pinIn` into the boundary register, and `pinIn[0]` is the first bit out. The update step copies the shifted-in bits to `pinOut`, and `extestMode` stays low.
- R7: Instruction codes 3'b011 through 3'b111 select the single-bit bypass register. This register captures 0, so the first bit out is 0 and each later bit out equals the bit shifted in one cycle earlier.
- R8: `tdoEn` is high only while the controller is in the instruction-shift or data-shift state, and `tdo` is 0 whenever `tdoEn` is low.
- R9: Passing through the data pause state keeps the partly shifted contents, and shifting resumes with the next bit.
- R10: `pinOut` resets to 0 and changes only in the data update step under instruction 3'b000 or 3'b010. Instruction loads and bypass scans leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| trstN | input | 1 | Asynchronous active-low test reset |
| pinIn | input | BSR_LEN | Pin values sampled by the boundary register |
| tdo | output | 1 | Serial data out, launched on the falling edge |
| tdoEn | output | 1 | Output enable for the serial-out pad |
| pinOut | output | BSR_LEN | Boundary update stage driven toward the pins |
| extestMode | output | 1 | High while the external-test instruction is active |

## Verification
The hardest case to reach from the ports is a scan that is stopped partway through a data shift, parked in the pause state, and then resumed. It needs an exact count of mode-select bits so that the exit, pause, second-exit and re-entry states fall between two specific data bits. The bench splits an identification read into a 12-bit segment and a 20-bit segment with two pause cycles between them, then joins the two segments and compares the result with the full code. A second hard case is reaching reset through the mode-select line alone from the middle of a data shift. The bench starts that sequence with the bypass instruction loaded, so only a real return to reset makes the identification code appear again.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT   = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b010;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tapState_t;

  typedef struct packed {
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic clearIr;
  } tapStrobes_t;

endpackage

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tms,
  output tapState_t   state,
  output tapStrobes_t strobes
);

  tapState_t nextState;

  always_comb begin
    unique case (state)
      ST_RESET:    nextState = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nextState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   nextState = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nextState = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: nextState = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: nextState = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nextState = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: nextState = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nextState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   nextState = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   nextState = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: nextState = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: nextState = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nextState = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: nextState = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   nextState = tms ? ST_SEL_DR   : ST_IDLE;
      default:     nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  always_comb begin
    strobes.captureIr = (state == ST_CAP_IR);
    strobes.shiftIr   = (state == ST_SHIFT_IR);
    strobes.updateIr  = (state == ST_UPD_IR);
    strobes.captureDr = (state == ST_CAP_DR);
    strobes.shiftDr   = (state == ST_SHIFT_DR);
    strobes.updateDr  = (state == ST_UPD_DR);
    strobes.clearIr   = (nextState == ST_RESET);
  end

endmodule

// File: rtl/scan_tap_dp.sv
module scan_tap_dp
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN = 8,
  parameter logic [31:0] ID_CODE = 32'h0C5A_E2D3
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                tdi,
  input  tapStrobes_t         strobes,
  input  logic [BSR_LEN-1:0]  pinIn,
  output logic [IR_W-1:0]     irStage,
  output logic [IR_W-1:0]     irActive,
  output logic [BSR_LEN-1:0]  pinOut,
  output logic                extestMode,
  output logic                tdo,
  output logic                tdoEn
);

  localparam int ID_W = 32;

  logic [ID_W-1:0]    idShift;
  logic               bypassBit;
  logic [BSR_LEN-1:0] bsrShift;
  logic               selBsr, selId, selByp, drBit, shifting;

  assign selBsr     = (irActive == OP_EXTEST) || (irActive == OP_SAMPLE);
  assign selId      = (irActive == OP_IDENT);
  assign selByp     = !selBsr && !selId;
  assign extestMode = (irActive == OP_EXTEST);

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irStage  <= IR_CAPTURE;
      irActive <= OP_IDENT;
    end else begin
      if (strobes.captureIr)    irStage <= IR_CAPTURE;
      else if (strobes.shiftIr) irStage <= {tdi, irStage[IR_W-1:1]};
      if (strobes.clearIr)       irActive <= OP_IDENT;
      else if (strobes.updateIr) irActive <= irStage;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      idShift   <= '0;
      bypassBit <= 1'b0;
    end else begin
      if (strobes.captureDr && selId)    idShift <= ID_CODE;
      else if (strobes.shiftDr && selId) idShift <= {tdi, idShift[ID_W-1:1]};
      if (strobes.captureDr && selByp)    bypassBit <= 1'b0;
      else if (strobes.shiftDr && selByp) bypassBit <= tdi;
    end
  end

  generate
    if (BSR_LEN == 1) begin : g_bsrSingle
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN)                          bsrShift <= '0;
        else if (strobes.captureDr && selBsr) bsrShift <= pinIn;
        else if (strobes.shiftDr && selBsr)   bsrShift <= tdi;
      end
    end else begin : g_bsrChain
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN)                          bsrShift <= '0;
        else if (strobes.captureDr && selBsr) bsrShift <= pinIn;
        else if (strobes.shiftDr && selBsr)   bsrShift <= {tdi, bsrShift[BSR_LEN-1:1]};
      end
    end
  endgenerate

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                          pinOut <= '0;
    else if (strobes.updateDr && selBsr) pinOut <= bsrShift;
  end

  assign drBit    = selBsr ? bsrShift[0] : (selId ? idShift[0] : bypassBit);
  assign shifting = strobes.shiftIr || strobes.shiftDr;

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= shifting;
      tdo   <= shifting ? (strobes.shiftIr ? irStage[0] : drBit) : 1'b0;
    end
  end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN = 8,
  parameter logic [31:0] ID_CODE = 32'h0C5A_E2D3
) (
  input  logic               tck,
  input  logic               tms,
  input  logic               tdi,
  input  logic               trstN,
  input  logic [BSR_LEN-1:0] pinIn,
  output logic               tdo,
  output logic               tdoEn,
  output logic [BSR_LEN-1:0] pinOut,
  output logic               extestMode
);

  tapState_t       tapState;
  tapStrobes_t     strobes;
  logic [IR_W-1:0] irStage;
  logic [IR_W-1:0] irActive;

  scan_tap_ctrl u_ctrl (
    .tck     (tck),
    .trstN   (trstN),
    .tms     (tms),
    .state   (tapState),
    .strobes (strobes)
  );

  scan_tap_dp #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE)) u_dp (
    .tck        (tck),
    .trstN      (trstN),
    .tdi        (tdi),
    .strobes    (strobes),
    .pinIn      (pinIn),
    .irStage    (irStage),
    .irActive   (irActive),
    .pinOut     (pinOut),
    .extestMode (extestMode),
    .tdo        (tdo),
    .tdoEn      (tdoEn)
  );

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int BSR_LEN = 8
) (
  input logic               tck,
  input logic               trstN,
  input logic               tms,
  input tapState_t          state,
  input logic [IR_W-1:0]    irStage,
  input logic [IR_W-1:0]    irActive,
  input logic [BSR_LEN-1:0] pinOut,
  input logic               tdo,
  input logic               tdoEn
);

  logic [2:0] highRun;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)      highRun <= '0;
    else if (!tms)   highRun <= '0;
    else if (highRun != 3'd5) highRun <= highRun + 3'd1;
  end

  AST_TMS_RETURNS_RESET: assert property (@(posedge tck) disable iff (!trstN)
    (highRun == 3'd5) |-> (state == ST_RESET)); // R2

  AST_RESET_HOLDS_IDENT: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_RESET) |-> (irActive == OP_IDENT)); // R3

  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_CAP_IR) |=> (irStage == IR_CAPTURE)); // R4

  AST_IR_UPDATE_COPIES: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_UPD_IR) |=> (irActive == $past(irStage))); // R4

  AST_TDO_EN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (state == ST_SHIFT_IR || state == ST_SHIFT_DR)); // R8

  AST_TDO_QUIET_WHEN_OFF: assert property (@(posedge tck) disable iff (!trstN)
    !tdoEn |-> !tdo); // R8

  AST_PINOUT_HELD: assert property (@(posedge tck) disable iff (!trstN)
    (state != ST_UPD_DR) |=> $stable(pinOut)); // R10

endmodule

bind scan_tap scan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck      (tck),
  .trstN    (trstN),
  .tms      (tms),
  .state    (tapState),
  .irStage  (irStage),
  .irActive (irActive),
  .pinOut   (pinOut),
  .tdo      (tdo),
  .tdoEn    (tdoEn)
);

// File: tb/scan_tap_bench.sv
module scan_tap_bench;

  localparam int          CLK_PERIOD = 20;
  localparam int          NPIN       = 8;
  localparam logic [31:0] EXP_ID     = 32'h0C5A_E2D3;

  logic            tck = 1'b0;
  logic            tms = 1'b1;
  logic            tdi = 1'b0;
  logic            trstN = 1'b0;
  logic [NPIN-1:0] pinIn = '0;
  logic            tdo, tdoEn, extestMode;
  logic [NPIN-1:0] pinOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) tck = ~tck;

  scan_tap #(.BSR_LEN(NPIN), .ID_CODE(EXP_ID)) u_scan_tap (
    .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN), .pinIn(pinIn),
    .tdo(tdo), .tdoEn(tdoEn), .pinOut(pinOut), .extestMode(extestMode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one test clock: inputs set away from edges, returns just after the falling edge
  task automatic tick(input logic tmsV, input logic tdiV);
    tms = tmsV;
    tdi = tdiV;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic goShiftIr(); // from idle
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
  endtask

  task automatic goShiftDr(); // from idle
    tick(1, 0); tick(0, 0); tick(0, 0);
  endtask

  // shifts n bits, leaving the shift state on the last one
  task automatic shiftBits(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    check("R8", 32'(tdoEn), 32'd1, "tdoEn in shift");
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
  endtask

  task automatic loadIr(input logic [2:0] code);
    logic [31:0] cap;
    goShiftIr();
    shiftBits(3, 32'(code), cap);
    check("R4", cap, 32'h1, "instruction capture pattern");
    tick(1, 0); // update
    tick(0, 0); // idle
  endtask

  task automatic scanDr(input int n, input logic [31:0] din, output logic [31:0] dout);
    goShiftDr();
    shiftBits(n, din, dout);
    tick(1, 0); // update
    tick(0, 0); // idle
  endtask

  task automatic t_reset();
    logic [31:0] got;
    check("R8", 32'(tdoEn), 32'd0, "tdoEn during reset");
    check("R10", 32'(pinOut), 32'd0, "pinOut reset value");
    @(negedge tck);
    trstN = 1'b1;
    tick(0, 0);
    scanDr(32, 32'h0, got);
    check("R3", got, EXP_ID, "identify code after reset");
  endtask

  task automatic t_edges();
    logic [31:0] got;
    loadIr(3'b111);
    goShiftDr();
    check("R7", 32'(tdo), 32'd0, "bypass first bit");
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    check("R1", 32'(tdo), 32'd0, "tdo held after rising edge");
    @(negedge tck); #1;
    check("R1", 32'(tdo), 32'd1, "tdo moves on falling edge");
    shiftBits(1, 32'h0, got);
    tick(1, 0); tick(0, 0);
    check("R8", 32'(tdoEn), 32'd0, "tdoEn in idle");
  endtask

  task automatic t_bypass();
    logic [31:0] got;
    loadIr(3'b111);
    scanDr(8, 32'hB2, got);
    check("R7", got, 32'h64, "bypass code 111 one-cycle delay");
    loadIr(3'b011);
    scanDr(8, 32'h5D, got);
    check("R7", got, 32'hBA, "bypass code 011 one-cycle delay");
    check("R10", 32'(pinOut), 32'h0, "pinOut untouched by bypass");
  endtask

  task automatic t_tmsReset();
    logic [31:0] got;
    loadIr(3'b100);
    goShiftDr();
    for (int i = 0; i < 5; i++) tick(1, 0);
    check("R8", 32'(tdoEn), 32'd0, "tdoEn in reset via mode select");
    tick(0, 0);
    scanDr(32, 32'h0, got);
    check("R2", got, EXP_ID, "five high mode-select edges restore identify");
  endtask

  task automatic t_sample();
    logic [31:0] got;
    pinIn = 8'h5A;
    loadIr(3'b010);
    check("R6", 32'(extestMode), 32'd0, "extestMode under sample");
    check("R10", 32'(pinOut), 32'h0, "pinOut after instruction load");
    scanDr(8, 32'hC3, got);
    check("R6", got, 32'h5A, "sampled pins shifted out");
    check("R6", 32'(pinOut), 32'hC3, "preload reaches pinOut");
  endtask

  task automatic t_extest();
    logic [31:0] got;
    loadIr(3'b000);
    check("R5", 32'(extestMode), 32'd1, "extestMode under external test");
    check("R10", 32'(pinOut), 32'hC3, "pinOut kept across instruction load");
    pinIn = 8'h0F;
    scanDr(8, 32'h81, got);
    check("R5", got, 32'h0F, "boundary capture under external test");
    check("R5", 32'(pinOut), 32'h81, "update drives pinOut");
  endtask

  task automatic t_pause();
    logic [31:0] lo, hi;
    loadIr(3'b001);
    check("R5", 32'(extestMode), 32'd0, "extestMode cleared by identify");
    goShiftDr();
    shiftBits(12, 32'h0, lo);      // ends in exit1
    tick(0, 0); tick(0, 0);        // pause twice
    check("R8", 32'(tdoEn), 32'd0, "tdoEn in pause");
    tick(1, 0);                    // exit2
    tick(0, 0);                    // back to shift
    shiftBits(20, 32'h0, hi);
    tick(1, 0); tick(0, 0);
    check("R9", (hi << 12) | (lo & 32'hFFF), EXP_ID, "identify read split by pause");
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    t_reset();
    t_edges();
    t_bypass();
    t_tmsReset();
    t_sample();
    t_extest();
    t_pause();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule